// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a 32-bit load/store pipeline and a word-wide data memory port. It turns a byte address, an access size and an optional store value into a word-aligned memory request. That request carries per-lane write enables and write data shifted into the addressed lanes. On the way back, it picks the addressed byte, halfword or word out of the returned memory word. The picked value is then extended with its sign or with zeros to 32 bits.

A runtime input chooses which byte order is used to number the bytes inside a word. In little-endian order, byte offset 0 is the least significant lane. In big-endian order, byte offset 0 is the most significant lane. An access whose address is not a multiple of its size is not split. Instead it is flagged as an alignment fault, and no memory transaction is issued for it.

The memory is expected to return read data in the cycle after the request. The response (load data or store completion, together with the fault flag) appears in that same cycle.

Top module: `lsu_align_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, rsp_load_valid, rsp_store_done, rsp_fault are low and rsp_rdata is zero.
- R2: req_size encodes 0 = byte, 1 = halfword, 2 = word. For an aligned request, mem_req is high and mem_we equals req_store in the same cycle. mem_be sets the lanes the access covers. A byte at offset k uses lane k in little-endian mode and lane 3-k in big-endian mode. A halfword covers lanes 1:0 or 3:2. A word covers all four lanes.
- R3: For an aligned store, mem_wdata carries the low 8 or 16 bits (or all 32) of req_wdata in the enabled lanes, in the byte order selected by cfg_big_endian (1 = big-endian), with zeros in the other lanes.
- R4: A halfword at an odd address, or a word at an address whose low two bits are nonzero, is misaligned. For a misaligned request, mem_req, mem_we and all mem_be bits are low in that cycle.
- R5: One cycle after an aligned load, rsp_rdata holds the addressed byte, halfword or word of mem_rdata, assembled in the selected byte order.
- R6: With req_signed high, byte and halfword loads copy the top bit of the field into the upper bits of rsp_rdata. With req_signed low, the upper bits are zero. Word loads are unaffected by req_signed.
- R7: Exactly one cycle after every request, either rsp_load_valid (for loads) or rsp_store_done (for stores) is high for one cycle. rsp_fault in that cycle reports whether the request was misaligned. A faulted load returns zero data.
- R8: mem_addr equals req_addr with its two low bits cleared.
- R9: The reserved size code 3 is treated as a fault, with no memory request.
- R10: The byte order used for a load's data is the one in force when the request was issued, even if cfg_big_endian changes before the data returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_big_endian | input | 1 | 1 selects big-endian byte numbering |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed | input | 1 | Sign-extend a byte or halfword load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store value, right-justified |
| mem_req | output | 1 | Memory transaction strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-shifted write data |
| mem_rdata | input | 32 | Read word, valid the cycle after mem_req |
| rsp_load_valid | output | 1 | Load response |
| rsp_store_done | output | 1 | Store completion |
| rsp_fault | output | 1 | Alignment fault for the answered request |
| rsp_rdata | output | 32 | Extracted, extended load data |

## Verification
Byte accesses are swept over all four offsets in both byte orders. This separates a swapped lane mapping from a correct one, because one fixed memory word with a distinct value in every byte is read back. Halfword accesses at offsets 0 and 2 in both orders show whether the two bytes inside the halfword are swapped. Loads are repeated signed and unsigned on bytes whose top bit is set and on bytes whose top bit is clear, which tells sign extension apart from zero filling. Odd halfword addresses, unaligned word addresses and the reserved size code check that the fault suppresses the request. A load whose byte order changes between issue and response shows whether the order is captured at issue.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // number of bytes an access of this size covers (0 for reserved)
  function automatic int size_bytes(acc_size_e s);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return LANES;
      default: return 0;
    endcase
  endfunction

  // alignment rule: address must be a multiple of the access size
  function automatic logic is_misaligned(acc_size_e s, logic [OFF_W-1:0] off);
    case (s)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return off[0];
      SZ_WORD: return off != '0;
      default: return 1'b1;
    endcase
  endfunction

  // lowest lane occupied by the access
  function automatic logic [OFF_W-1:0] lane_shift(acc_size_e s, logic [OFF_W-1:0] off,
                                                  logic big_end);
    int t;
    if (!big_end) return off;
    t = LANES - size_bytes(s) - int'(off);
    if (t < 0) t = 0;
    return OFF_W'(t);
  endfunction

  // lanes covered, right-justified
  function automatic logic [LANES-1:0] size_mask(acc_size_e s);
    logic [LANES-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++)
      if (i < size_bytes(s)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/lsu_store_path.sv
module lsu_store_path
  import lsu_align_pkg::*;
(
  input  acc_size_e          size,
  input  logic [OFF_W-1:0]   shift,
  input  logic               fault,
  input  logic [DATA_W-1:0]  wdata,
  output logic [LANES-1:0]   lane_en,
  output logic [DATA_W-1:0]  wdata_sh
);
  logic [LANES-1:0]  fmask;
  logic [DATA_W-1:0] dmask;

  assign fmask = size_mask(size);

  for (genvar g = 0; g < LANES; g++) begin : g_dmask
    assign dmask[8*g +: 8] = {8{fmask[g]}};
  end

  always_comb begin
    if (fault) begin
      lane_en  = '0;
      wdata_sh = '0;
    end else begin
      lane_en  = fmask << shift;
      wdata_sh = (wdata & dmask) << {shift, 3'b000};
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
(
  input  acc_size_e          size,
  input  logic [OFF_W-1:0]   shift,
  input  logic               sign_ext,
  input  logic               fault,
  input  logic [DATA_W-1:0]  rdata,
  output logic [DATA_W-1:0]  data
);
  logic [DATA_W-1:0] aligned;

  assign aligned = rdata >> {shift, 3'b000};

  always_comb begin
    data = '0;
    if (!fault) begin
      case (size)
        SZ_BYTE: data = {{(DATA_W-8){sign_ext & aligned[7]}}, aligned[7:0]};
        SZ_HALF: data = {{(DATA_W-16){sign_ext & aligned[15]}}, aligned[15:0]};
        SZ_WORD: data = aligned;
        default: data = '0;
      endcase
    end
  end
endmodule

// File: rtl/lsu_rsp_reg.sv
module lsu_rsp_reg
  import lsu_align_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_store,
  input  acc_size_e        in_size,
  input  logic [OFF_W-1:0] in_shift,
  input  logic             in_signed,
  input  logic             in_fault,
  output logic             q_valid,
  output logic             q_store,
  output acc_size_e        q_size,
  output logic [OFF_W-1:0] q_shift,
  output logic             q_signed,
  output logic             q_fault
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_store  <= 1'b0;
      q_size   <= SZ_BYTE;
      q_shift  <= '0;
      q_signed <= 1'b0;
      q_fault  <= 1'b0;
    end else begin
      q_valid  <= in_valid;
      q_store  <= in_valid & in_store;
      q_size   <= in_size;
      q_shift  <= in_shift;
      q_signed <= in_signed;
      q_fault  <= in_valid & in_fault;
    end
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_big_endian,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_load_valid,
  output logic              rsp_store_done,
  output logic              rsp_fault,
  output logic [DATA_W-1:0] rsp_rdata
);
  acc_size_e        size_in;
  logic [OFF_W-1:0] offset;
  logic [OFF_W-1:0] shift_now;
  logic             fault_now;
  logic             issue_ok;

  assign size_in   = acc_size_e'(req_size);
  assign offset    = req_addr[OFF_W-1:0];
  assign fault_now = is_misaligned(size_in, offset);
  assign shift_now = lane_shift(size_in, offset, cfg_big_endian);
  assign issue_ok  = req_valid & ~fault_now;

  logic [LANES-1:0] lane_en;

  lsu_store_path u_store (
    .size     (size_in),
    .shift    (shift_now),
    .fault    (fault_now),
    .wdata    (req_wdata),
    .lane_en  (lane_en),
    .wdata_sh (mem_wdata)
  );

  assign mem_req  = issue_ok;
  assign mem_we   = issue_ok & req_store;
  assign mem_be   = req_valid ? lane_en : '0;
  assign mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  logic             q_valid, q_store, q_signed, q_fault;
  acc_size_e        q_size;
  logic [OFF_W-1:0] q_shift;

  lsu_rsp_reg u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_store  (req_store),
    .in_size   (size_in),
    .in_shift  (shift_now),
    .in_signed (req_signed),
    .in_fault  (fault_now),
    .q_valid   (q_valid),
    .q_store   (q_store),
    .q_size    (q_size),
    .q_shift   (q_shift),
    .q_signed  (q_signed),
    .q_fault   (q_fault)
  );

  logic [DATA_W-1:0] load_data;

  lsu_load_extract u_load (
    .size     (q_size),
    .shift    (q_shift),
    .sign_ext (q_signed),
    .fault    (q_fault),
    .rdata    (mem_rdata),
    .data     (load_data)
  );

  assign rsp_load_valid = q_valid & ~q_store;
  assign rsp_store_done = q_store;
  assign rsp_fault      = q_fault;
  assign rsp_rdata      = rsp_load_valid ? load_data : '0;

  // R4 / R9: a faulted request never reaches memory
  a_r4_fault_blocks_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fault_now) |-> (!mem_req && !mem_we && mem_be == '0));

  // R2: a byte access enables exactly one lane
  a_r2_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && size_in == SZ_BYTE) |-> $countones(mem_be) == 1);

  // R7: every request answered by exactly one response kind next cycle
  a_r7_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_load_valid ^ rsp_store_done));

  // R7: fault reported one cycle after a misaligned request
  a_r7_fault_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fault_now) |=> rsp_fault);

  // R7: a faulted load returns zero data
  a_r7_fault_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_load_valid && rsp_fault) |-> rsp_rdata == '0);

  // R1: no response without a request in the previous cycle
  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_load_valid && !rsp_store_done && !rsp_fault));
endmodule

// File: tb/tb_lsu_align_unit.sv
`timescale 1ns/1ps
module tb_lsu_align_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_big_endian;
  logic        req_valid, req_store, req_signed;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic        rsp_load_valid, rsp_store_done, rsp_fault;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  lsu_align_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian),
    .req_valid(req_valid), .req_store(req_store), .req_size(req_size),
    .req_signed(req_signed), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_load_valid(rsp_load_valid), .rsp_store_done(rsp_store_done),
    .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata)
  );

  localparam logic [31:0] MEMWORD = 32'hC3A5_7E18;
  localparam logic [31:0] STVAL   = 32'h9E4D_B2F7;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  // memory byte at offset k, per byte order
  function automatic logic [7:0] mem_byte(input logic [31:0] w, input int k, input logic be);
    return be ? w[8*(3-k) +: 8] : w[8*k +: 8];
  endfunction

  task automatic do_store(input logic be, input logic [1:0] sz, input logic [31:0] addr);
    int n = nbytes(sz);
    int off = int'(addr[1:0]);
    logic [3:0] ebe = '0;
    logic [31:0] ewd = '0;
    for (int j = 0; j < n; j++) begin
      int lane = be ? 3 - (off + j) : off + j;
      int vb   = be ? n - 1 - j : j;
      ebe[lane] = 1'b1;
      ewd[8*lane +: 8] = STVAL[8*vb +: 8];
    end
    @(negedge clk);
    cfg_big_endian = be; req_valid = 1; req_store = 1; req_size = sz;
    req_signed = 0; req_addr = addr; req_wdata = STVAL;
    #2;
    chk("R2 mem_req", {31'd0, mem_req}, 32'd1);
    chk("R2 mem_we",  {31'd0, mem_we}, 32'd1);
    chk("R2 mem_be",  {28'd0, mem_be}, {28'd0, ebe});
    chk("R3 mem_wdata", mem_wdata, ewd);
    chk("R8 mem_addr", mem_addr, {addr[31:2], 2'b00});
    @(negedge clk);
    req_valid = 0;
    chk("R7 store_done", {31'd0, rsp_store_done}, 32'd1);
    chk("R7 no load_valid", {31'd0, rsp_load_valid}, 32'd0);
    chk("R7 no fault", {31'd0, rsp_fault}, 32'd0);
  endtask

  // flip_be: change byte order between issue and response (R10)
  task automatic do_load(input logic be, input logic [1:0] sz, input logic sgn,
                         input logic [31:0] addr, input logic flip_be);
    int n = nbytes(sz);
    int off = int'(addr[1:0]);
    logic [31:0] v = '0;
    logic [31:0] exp;
    for (int j = 0; j < n; j++) begin
      int vb = be ? n - 1 - j : j;
      v[8*vb +: 8] = mem_byte(MEMWORD, off + j, be);
    end
    exp = v;
    if (sgn && n < 4 && v[8*n-1])
      for (int b = 8*n; b < 32; b++) exp[b] = 1'b1;
    @(negedge clk);
    cfg_big_endian = be; req_valid = 1; req_store = 0; req_size = sz;
    req_signed = sgn; req_addr = addr; mem_rdata = MEMWORD;
    #2;
    chk("R2 load mem_req", {31'd0, mem_req}, 32'd1);
    chk("R2 load mem_we", {31'd0, mem_we}, 32'd0);
    @(negedge clk);
    req_valid = 0;
    if (flip_be) cfg_big_endian = ~be;
    #1;
    chk("R7 load_valid", {31'd0, rsp_load_valid}, 32'd1);
    chk("R7 load fault", {31'd0, rsp_fault}, 32'd0);
    if (flip_be) chk("R10 rdata order at issue", rsp_rdata, exp);
    else if (n < 4) chk(sgn ? "R6 signed rdata" : "R6 unsigned rdata", rsp_rdata, exp);
    else chk("R5 word rdata", rsp_rdata, exp);
  endtask

  task automatic do_fault(input logic st, input logic [1:0] sz, input logic [31:0] addr,
                          input string tag);
    @(negedge clk);
    cfg_big_endian = 0; req_valid = 1; req_store = st; req_size = sz;
    req_signed = 1; req_addr = addr; req_wdata = STVAL; mem_rdata = MEMWORD;
    #2;
    chk({tag, " mem_req low"}, {31'd0, mem_req}, 32'd0);
    chk({tag, " mem_we low"}, {31'd0, mem_we}, 32'd0);
    chk({tag, " mem_be zero"}, {28'd0, mem_be}, 32'd0);
    @(negedge clk);
    req_valid = 0;
    chk("R7 fault flag", {31'd0, rsp_fault}, 32'd1);
    chk("R7 handshake", {30'd0, rsp_load_valid, rsp_store_done}, st ? 32'd1 : 32'd2);
    if (!st) chk("R7 faulted load data", rsp_rdata, 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 0; cfg_big_endian = 0; req_valid = 1; req_store = 0; req_size = 0;
    req_signed = 0; req_addr = 0; req_wdata = 0; mem_rdata = MEMWORD;
    repeat (3) @(negedge clk);
    chk("R1 reset load_valid", {31'd0, rsp_load_valid}, 32'd0);
    chk("R1 reset store_done", {31'd0, rsp_store_done}, 32'd0);
    chk("R1 reset fault", {31'd0, rsp_fault}, 32'd0);
    chk("R1 reset rdata", rsp_rdata, 32'd0);
    req_valid = 0;
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {29'd0, rsp_load_valid, rsp_store_done, rsp_fault}, 32'd0);
  endtask

  task automatic t_sweep;
    for (int e = 0; e < 2; e++) begin
      for (int o = 0; o < 4; o++) begin
        do_store(e[0], 2'd0, 32'h0000_1230 + o);
        do_load(e[0], 2'd0, 1'b0, 32'h0000_1230 + o, 1'b0);
        do_load(e[0], 2'd0, 1'b1, 32'h0000_1230 + o, 1'b0);
      end
      for (int o = 0; o < 4; o += 2) begin
        do_store(e[0], 2'd1, 32'h0040_0100 + o);
        do_load(e[0], 2'd1, 1'b0, 32'h0040_0100 + o, 1'b0);
        do_load(e[0], 2'd1, 1'b1, 32'h0040_0100 + o, 1'b0);
      end
      do_store(e[0], 2'd2, 32'hFFFF_FFFC);
      do_load(e[0], 2'd2, 1'b1, 32'h0000_0008, 1'b0);
    end
  endtask

  task automatic t_faults;
    do_fault(1'b1, 2'd1, 32'h0000_0101, "R4 half odd store");
    do_fault(1'b0, 2'd1, 32'h0000_0103, "R4 half odd load");
    do_fault(1'b1, 2'd2, 32'h0000_0102, "R4 word off2 store");
    do_fault(1'b0, 2'd2, 32'h0000_0101, "R4 word off1 load");
    do_fault(1'b0, 2'd3, 32'h0000_0100, "R9 reserved size load");
    do_fault(1'b1, 2'd3, 32'h0000_0100, "R9 reserved size store");
  endtask

  task automatic t_endian_capture;
    do_load(1'b0, 2'd0, 1'b0, 32'h0000_0201, 1'b1);
    do_load(1'b1, 2'd1, 1'b0, 32'h0000_0202, 1'b1);
  endtask

  logic done = 1'b0;

  initial begin
    t_reset();
    t_sweep();
    t_faults();
    t_endian_capture();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule